// File: doc/BRIEF.md
# Standby Wake-Up Sequencer

This block decides when a chip that has dropped into its low-power standby state may run again. Software arms standby by setting a standby flag and then issuing a one-cycle sleep pulse. While the chip is asleep, the chip clock enable is low. An edge of the chosen polarity on the non-maskable request line, or on any of the maskable request lines, starts a settling interval. There is no interrupt mask input, so a wake edge is honoured whatever masking the processor has in force. The settling interval is timed by an 8-bit up-counter that software preloads, which advances once per divided tick. Clocks come back on the tick that carries the counter past its all-ones value. At that moment the block emits a one-cycle interrupt-taken pulse and presents a code that names the source.

After wake-up the same counter keeps running as a guard. If software clears the standby flag, the counter freezes and normal running resumes. If the counter reaches its midpoint value while the flag is still set, the chip falls into a locked standby. Only the power-on reset releases it. A manual reset line can cancel an ordinary standby and hold the chip in reset. That line is refused while the standby flag is set after wake-up. Throughout a reset hold the clock enable stays high, so the clock output keeps running.

Top module: `stby_wake_seq`

## Requirements
- R1: While `rstPorN` is low, `chipRstN` is low. After release the block is running: `status` = 2'b00, `chipClkEn` = 1, `cntVal` = 8'h00, `intTaken` = 0, and the standby flag is clear.
- R2: A `sleepReq` pulse sampled while running with the standby flag set enters standby on that edge: `status` = 2'b11 and `chipClkEn` = 0. With the flag clear, a `sleepReq` pulse changes nothing.
- R3: In standby, an edge on `nmiIn` or on any `irqIn[k]` starts settling. The edge polarity follows its select bit, where 1 means rising and 0 means falling. An edge of the other polarity does not start settling.
- R4: The counter holds its value in standby before a wake edge. During settling it adds one on each clock edge that samples `tick` high. On the tick that finds 8'hFF, the counter wraps to 8'h00, `chipClkEn` rises and `status` becomes 2'b00. A preload P therefore takes 256−P ticks.
- R5: `intTaken` is high for exactly the one cycle that follows the wake edge of R4. The code is latched when the wake edge is seen: 8'h1C for NMI and 8'h20+k for `irqIn[k]`. NMI outranks all IRQs, and among IRQs the lowest index wins.
- R6: After wake-up the counter keeps advancing per tick while the standby flag stays set. Clearing the flag stops the counter, and the block returns to running.
- R7: If a clock edge after wake-up finds the counter at 8'h80 with the flag still set, the block enters locked standby: `status` = 2'b10 and `chipClkEn` = 0. This happens even when a flag-clear write is sampled on that same edge.
- R8: In locked standby, wake edges, manual reset and register writes have no effect. Only `rstPorN` exits it.
- R9: A low `manRstN` is refused while the standby flag is set, both when running and after wake-up. When running with the flag clear, `chipRstN` goes low from the edge that samples `manRstN` low until the edge that samples it high.
- R10: A low `manRstN` sampled in standby or during settling cancels standby and clears the flag. The block then runs, holding `chipRstN` low while `chipClkEn` stays high.
- R11: Counter writes (`cntWrEn`) are accepted only while running. In every other state they are ignored.
- R12: Standby-flag writes (`stbyWrEn`) are accepted only while running or after wake-up with the flag still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstPorN | input | 1 | Power-on reset, active low, asynchronous |
| manRstN | input | 1 | Manual reset request, active low |
| nmiIn | input | 1 | Non-maskable wake request line |
| nmiRiseSel | input | 1 | NMI polarity: 1 rising, 0 falling |
| irqIn | input | NUM_IRQ | Maskable wake request lines |
| irqRiseSel | input | NUM_IRQ | Per-line polarity: 1 rising, 0 falling |
| sleepReq | input | 1 | One-cycle sleep request |
| tick | input | 1 | Divided-clock tick for the counter |
| stbyWrEn | input | 1 | Standby flag write strobe |
| stbyWrData | input | 1 | Standby flag write value |
| cntWrEn | input | 1 | Counter write strobe |
| cntWrData | input | CNT_W | Counter write value |
| chipClkEn | output | 1 | Chip-wide clock enable |
| chipRstN | output | 1 | Chip reset, active low |
| status | output | 2 | 11 standby, 00 running, 10 locked |
| intTaken | output | 1 | One-cycle pulse at wake-up |
| intCode | output | CODE_W | Latched wake source code |
| cntVal | output | CNT_W | Settling/guard counter value |

## Verification
Two events can land on the same clock edge: the guard check finding the counter at 8'h80, and a software write clearing the standby flag. The bench provokes this both ways. In one case the clear write is sampled on the same edge that first sees 8'h80, and the block is expected to lock. In the other case the write is sampled on the edge where the counter steps from 8'h7F to 8'h80, and the block is expected to return to running with the counter frozen at 8'h80. Competing wake sources on a single edge and a manual reset that arrives while the flag is still set are judged the same way, by reading the state from `status`, `intCode` and `chipRstN`.

// File: rtl/swc_pkg.sv
package swc_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_DOZE   = 3'd1,
    ST_SETTLE = 3'd2,
    ST_GUARD  = 3'd3,
    ST_LOCK   = 3'd4
  } swcState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic cntLoad;
    logic cntInc;
    logic codeLatch;
  } swcStrobe_t;

  localparam logic [1:0] STAT_RUN  = 2'b00;
  localparam logic [1:0] STAT_DOZE = 2'b11;
  localparam logic [1:0] STAT_LOCK = 2'b10;

endpackage

// File: rtl/swc_edge_det.sv
module swc_edge_det (
  input  logic clk,
  input  logic rstPorN,
  input  logic lineIn,
  input  logic riseSel,
  output logic edgeHit
);

  logic lineQ;

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) lineQ <= 1'b0;
    else          lineQ <= lineIn;
  end

  assign edgeHit = riseSel ? (lineIn & ~lineQ) : (~lineIn & lineQ);

endmodule

// File: rtl/swc_datapath.sv
module swc_datapath
  import swc_pkg::*;
#(
  parameter int NUM_IRQ = 4,
  parameter int CNT_W = 8,
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] NMI_CODE = 'h1C,
  parameter logic [CODE_W-1:0] IRQ_BASE = 'h20
) (
  input  logic               clk,
  input  logic               rstPorN,
  input  logic               nmiIn,
  input  logic               nmiRiseSel,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic [NUM_IRQ-1:0] irqRiseSel,
  input  swcStrobe_t         stb,
  input  logic [CNT_W-1:0]   cntWrData,
  output logic               wakeEdge,
  output logic               cntAtTop,
  output logic               cntAtMid,
  output logic [CNT_W-1:0]   cntVal,
  output logic [CODE_W-1:0]  intCode
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MID = {1'b1, {(CNT_W-1){1'b0}}};

  logic               nmiEdge;
  logic [NUM_IRQ-1:0] irqEdge;
  logic [CODE_W-1:0]  selCode;
  logic [CNT_W-1:0]   cntQ;
  logic [CODE_W-1:0]  codeQ;

  swc_edge_det nmiDet_i (
    .clk(clk), .rstPorN(rstPorN), .lineIn(nmiIn),
    .riseSel(nmiRiseSel), .edgeHit(nmiEdge)
  );

  for (genvar g = 0; g < NUM_IRQ; g++) begin : gIrqDet
    swc_edge_det irqDet_i (
      .clk(clk), .rstPorN(rstPorN), .lineIn(irqIn[g]),
      .riseSel(irqRiseSel[g]), .edgeHit(irqEdge[g])
    );
  end

  // NMI first, then the lowest IRQ index
  always_comb begin
    selCode = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (irqEdge[i]) selCode = IRQ_BASE + CODE_W'(i);
    end
    if (nmiEdge) selCode = NMI_CODE;
  end

  assign wakeEdge = nmiEdge | (|irqEdge);

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      cntQ <= '0;
    end else if (stb.cntLoad) begin
      cntQ <= cntWrData;
    end else if (stb.cntInc) begin
      cntQ <= cntQ + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN)           codeQ <= '0;
    else if (stb.codeLatch) codeQ <= selCode;
  end

  assign cntVal   = cntQ;
  assign cntAtTop = (cntQ == CNT_TOP);
  assign cntAtMid = (cntQ == CNT_MID);
  assign intCode  = codeQ;

  // R5: an NMI edge latched on a wake gives the NMI code
  assert_nmi_code_R5: assert property (@(posedge clk) disable iff (!rstPorN)
    (stb.codeLatch && nmiEdge) |=> (intCode == NMI_CODE));

  // R4: an increment of the all-ones count wraps to zero
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rstPorN)
    (stb.cntInc && !stb.cntLoad && cntQ == CNT_TOP) |=> (cntQ == '0));

endmodule

// File: rtl/swc_control.sv
module swc_control
  import swc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstPorN,
  input  logic             manRstN,
  input  logic             sleepReq,
  input  logic             tick,
  input  logic             stbyWrEn,
  input  logic             stbyWrData,
  input  logic             cntWrEn,
  input  logic             wakeEdge,
  input  logic             cntAtTop,
  input  logic             cntAtMid,
  input  logic [CNT_W-1:0] cntVal,
  output swcStrobe_t       stb,
  output logic             chipClkEn,
  output logic             chipRstN,
  output logic [1:0]       status,
  output logic             intTaken
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MID = {1'b1, {(CNT_W-1){1'b0}}};

  swcState_e state, nextState;
  logic      stbyBit;
  logic      manHold;
  logic      manAccept;
  logic      manReq;
  logic      flagWrOk;

  assign manAccept = (state == ST_RUN && !stbyBit) || state == ST_DOZE || state == ST_SETTLE;
  assign manReq    = !manRstN && manAccept;
  assign flagWrOk  = (state == ST_RUN) || (state == ST_GUARD);

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      ST_RUN: begin
        stb.cntLoad = cntWrEn;
        if (!manReq && sleepReq && stbyBit) nextState = ST_DOZE;
      end
      ST_DOZE: begin
        if (manReq) begin
          nextState = ST_RUN;
        end else if (wakeEdge) begin
          stb.codeLatch = 1'b1;
          nextState     = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (manReq) begin
          nextState = ST_RUN;
        end else if (tick) begin
          stb.cntInc = 1'b1;
          if (cntAtTop) nextState = ST_GUARD;
        end
      end
      ST_GUARD: begin
        if (!stbyBit)      nextState = ST_RUN;
        else if (cntAtMid) nextState = ST_LOCK;
        else               stb.cntInc = tick;
      end
      ST_LOCK: nextState = ST_LOCK;
      default: nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      state    <= ST_RUN;
      stbyBit  <= 1'b0;
      manHold  <= 1'b0;
      intTaken <= 1'b0;
    end else begin
      state    <= nextState;
      manHold  <= manReq;
      intTaken <= (state == ST_SETTLE) && (nextState == ST_GUARD);
      if (manReq)                    stbyBit <= 1'b0;
      else if (stbyWrEn && flagWrOk) stbyBit <= stbyWrData;
    end
  end

  always_comb begin
    unique case (state)
      ST_DOZE, ST_SETTLE: begin chipClkEn = 1'b0; status = STAT_DOZE; end
      ST_LOCK:            begin chipClkEn = 1'b0; status = STAT_LOCK; end
      default:            begin chipClkEn = 1'b1; status = STAT_RUN;  end
    endcase
  end

  assign chipRstN = rstPorN & ~manHold;

  // R8: locked standby is left only by power-on reset
  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rstPorN)
    (state == ST_LOCK) |=> (state == ST_LOCK));

  // R7: midpoint with flag set after wake-up locks
  assert_lock_entry_R7: assert property (@(posedge clk) disable iff (!rstPorN)
    (state == ST_GUARD && stbyBit && cntVal == CNT_MID) |=> (status == STAT_LOCK));

  // R4: tick on all-ones during settling restores clocks with a wrapped counter
  assert_wake_R4: assert property (@(posedge clk) disable iff (!rstPorN)
    (state == ST_SETTLE && manRstN && tick && cntVal == CNT_TOP)
      |=> (chipClkEn && cntVal == '0 && intTaken));

  // R9: manual reset refused while the flag is set outside standby
  assert_man_refused_R9: assert property (@(posedge clk) disable iff (!rstPorN)
    (stbyBit && !manRstN && state != ST_DOZE && state != ST_SETTLE) |=> chipRstN);

  // R11: counter moves only by a running-state write or by counting states
  assert_cnt_hold_R11: assert property (@(posedge clk) disable iff (!rstPorN)
    (state != ST_SETTLE && state != ST_GUARD && !(state == ST_RUN && cntWrEn))
      |=> $stable(cntVal));

endmodule

// File: rtl/stby_wake_seq.sv
module stby_wake_seq
  import swc_pkg::*;
#(
  parameter int NUM_IRQ = 4,
  parameter int CNT_W = 8,
  parameter int CODE_W = 8
) (
  input  logic               clk,
  input  logic               rstPorN,
  input  logic               manRstN,
  input  logic               nmiIn,
  input  logic               nmiRiseSel,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic [NUM_IRQ-1:0] irqRiseSel,
  input  logic               sleepReq,
  input  logic               tick,
  input  logic               stbyWrEn,
  input  logic               stbyWrData,
  input  logic               cntWrEn,
  input  logic [CNT_W-1:0]   cntWrData,
  output logic               chipClkEn,
  output logic               chipRstN,
  output logic [1:0]         status,
  output logic               intTaken,
  output logic [CODE_W-1:0]  intCode,
  output logic [CNT_W-1:0]   cntVal
);

  swcStrobe_t stb;
  logic       wakeEdge;
  logic       cntAtTop;
  logic       cntAtMid;

  swc_control #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstPorN(rstPorN), .manRstN(manRstN), .sleepReq(sleepReq),
    .tick(tick), .stbyWrEn(stbyWrEn), .stbyWrData(stbyWrData),
    .cntWrEn(cntWrEn), .wakeEdge(wakeEdge), .cntAtTop(cntAtTop),
    .cntAtMid(cntAtMid), .cntVal(cntVal), .stb(stb), .chipClkEn(chipClkEn),
    .chipRstN(chipRstN), .status(status), .intTaken(intTaken)
  );

  swc_datapath #(.NUM_IRQ(NUM_IRQ), .CNT_W(CNT_W), .CODE_W(CODE_W)) dp_i (
    .clk(clk), .rstPorN(rstPorN), .nmiIn(nmiIn), .nmiRiseSel(nmiRiseSel),
    .irqIn(irqIn), .irqRiseSel(irqRiseSel), .stb(stb), .cntWrData(cntWrData),
    .wakeEdge(wakeEdge), .cntAtTop(cntAtTop), .cntAtMid(cntAtMid),
    .cntVal(cntVal), .intCode(intCode)
  );

endmodule

// File: tb/stby_wake_seq_tb_top.sv
module stby_wake_seq_tb_top;

  localparam int N = 4;

  logic clk = 1'b0;
  logic rstPorN, manRstN, nmiIn, nmiRiseSel, sleepReq, tick;
  logic stbyWrEn, stbyWrData, cntWrEn;
  logic [N-1:0] irqIn, irqRiseSel;
  logic [7:0] cntWrData;
  logic chipClkEn, chipRstN, intTaken;
  logic [1:0] status;
  logic [7:0] intCode, cntVal;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  stby_wake_seq #(.NUM_IRQ(N), .CNT_W(8), .CODE_W(8)) dut_i (
    .clk(clk), .rstPorN(rstPorN), .manRstN(manRstN), .nmiIn(nmiIn),
    .nmiRiseSel(nmiRiseSel), .irqIn(irqIn), .irqRiseSel(irqRiseSel),
    .sleepReq(sleepReq), .tick(tick), .stbyWrEn(stbyWrEn), .stbyWrData(stbyWrData),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData), .chipClkEn(chipClkEn),
    .chipRstN(chipRstN), .status(status), .intTaken(intTaken),
    .intCode(intCode), .cntVal(cntVal)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic setIdle(input logic pol);
    nmiRiseSel = pol;
    irqRiseSel = {N{pol}};
    nmiIn      = ~pol;
    irqIn      = {N{~pol}};
  endtask

  task automatic porPulse();
    rstPorN = 1'b0;
    #1;
    chk("R1", "chipRstN in reset", chipRstN, 0);
    step();
    rstPorN = 1'b1;
    step();
    chk("R1", "status after reset", status, 2'b00);
    chk("R1", "clkEn after reset", chipClkEn, 1);
    chk("R1", "cnt after reset", cntVal, 8'h00);
  endtask

  task automatic enterStandby(input logic [7:0] pre);
    cntWrEn = 1'b1; cntWrData = pre; step(); cntWrEn = 1'b0;
    stbyWrEn = 1'b1; stbyWrData = 1'b1; step(); stbyWrEn = 1'b0;
    sleepReq = 1'b1; step(); sleepReq = 1'b0;
    chk("R2", "status in standby", status, 2'b11);
    chk("R2", "clkEn in standby", chipClkEn, 0);
  endtask

  // caller has just driven the wake edge
  task automatic settle(input logic [7:0] pre, input logic [7:0] expCode);
    step();
    chk("R5", "latched code", intCode, expCode);
    tick = 1'b1;
    for (int i = 0; i < 255 - int'(pre); i++) step();
    chk("R4", "still settling at FF", status, 2'b11);
    chk("R4", "cnt at FF", cntVal, 8'hFF);
    step();
    tick = 1'b0;
    chk("R4", "status after overflow", status, 2'b00);
    chk("R4", "clkEn after overflow", chipClkEn, 1);
    chk("R4", "cnt wrapped", cntVal, 8'h00);
    chk("R5", "intTaken pulse", intTaken, 1);
    step();
    chk("R5", "intTaken one cycle", intTaken, 0);
  endtask

  task automatic clearFlag();
    stbyWrEn = 1'b1; stbyWrData = 1'b0; step(); stbyWrEn = 1'b0;
    step();
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rstPorN = 1'b0; manRstN = 1'b1; sleepReq = 1'b0; tick = 1'b0;
    stbyWrEn = 1'b0; stbyWrData = 1'b0; cntWrEn = 1'b0; cntWrData = 8'h00;
    setIdle(1'b1);
    #1;
    chk("R1", "chipRstN during POR", chipRstN, 0);
    repeat (3) step();
    rstPorN = 1'b1;
    step();
    chk("R1", "status", status, 2'b00);
    chk("R1", "clkEn", chipClkEn, 1);
    chk("R1", "cnt", cntVal, 8'h00);
    chk("R1", "intTaken", intTaken, 0);
    chk("R1", "chipRstN released", chipRstN, 1);

    // R2: sleep with flag clear does nothing
    sleepReq = 1'b1; step(); sleepReq = 1'b0; step();
    chk("R2", "sleep with flag clear", status, 2'b00);

    // sweep: polarity x source
    for (int pol = 0; pol < 2; pol++) begin
      for (int src = 0; src <= N; src++) begin
        logic [7:0] pre;
        logic [7:0] code;
        pre  = 8'hF0 + 8'(src * 3 + pol);
        code = (src == 0) ? 8'h1C : 8'h20 + 8'(src - 1);
        setIdle(pol[0]);
        step(); step();
        enterStandby(pre);
        tick = 1'b1; step(); step(); tick = 1'b0;
        chk("R4", "no count before wake", cntVal, pre);
        cntWrEn = 1'b1; cntWrData = 8'h55; step(); cntWrEn = 1'b0;
        chk("R11", "write ignored in standby", cntVal, pre);
        if (src == 0) nmiIn = pol[0];
        else          irqIn[src-1] = pol[0];
        settle(pre, code);
        setIdle(pol[0]);
        clearFlag();
        tick = 1'b1; step(); step(); step(); tick = 1'b0;
        chk("R6", "counter stopped after clear", cntVal, 8'h00);
        chk("R6", "running after clear", status, 2'b00);
        sleepReq = 1'b1; step(); sleepReq = 1'b0;
        chk("R12", "flag cleared by write", status, 2'b00);
      end
    end

    // R5 priority: NMI over IRQ
    setIdle(1'b1); step(); step();
    enterStandby(8'hFC);
    nmiIn = 1'b1; irqIn[2] = 1'b1;
    settle(8'hFC, 8'h1C);
    clearFlag();
    // R5 priority: lower IRQ index first
    setIdle(1'b1); step(); step();
    enterStandby(8'hFC);
    irqIn[1] = 1'b1; irqIn[3] = 1'b1;
    settle(8'hFC, 8'h21);
    clearFlag();

    // R3 wrong polarity
    setIdle(1'b1); nmiIn = 1'b1; step(); step();
    enterStandby(8'hFD);
    nmiIn = 1'b0; step(); step();
    chk("R3", "falling edge with rising select", status, 2'b11);
    nmiIn = 1'b1;
    settle(8'hFD, 8'h1C);
    clearFlag();

    // R7/R8 lock path, R9 refused in guard
    setIdle(1'b1); step(); step();
    enterStandby(8'hFE);
    nmiIn = 1'b1;
    settle(8'hFE, 8'h1C);
    nmiIn = 1'b0;
    manRstN = 1'b0; step(); step();
    chk("R9", "manual reset refused after wake", chipRstN, 1);
    chk("R9", "still running", status, 2'b00);
    manRstN = 1'b1;
    tick = 1'b1;
    for (int i = 0; i < 128; i++) step();
    tick = 1'b0;
    chk("R6", "guard count reached 80", cntVal, 8'h80);
    chk("R7", "not yet locked", status, 2'b00);
    step();
    chk("R7", "locked", status, 2'b10);
    chk("R7", "clk off in lock", chipClkEn, 0);
    nmiIn = 1'b1; step(); step();
    chk("R8", "wake edge in lock", status, 2'b10);
    manRstN = 1'b0; step();
    chk("R8", "manual reset in lock", chipRstN, 1);
    chk("R8", "status after manual", status, 2'b10);
    manRstN = 1'b1;
    cntWrEn = 1'b1; cntWrData = 8'h11; step(); cntWrEn = 1'b0;
    chk("R8", "cnt write in lock", cntVal, 8'h80);
    clearFlag();
    chk("R8", "flag write in lock", status, 2'b10);
    porPulse();

    // R7 same-edge clear loses to the lock check
    setIdle(1'b1); step(); step();
    enterStandby(8'hFE);
    nmiIn = 1'b1;
    settle(8'hFE, 8'h1C);
    tick = 1'b1;
    for (int i = 0; i < 128; i++) step();
    tick = 1'b0;
    stbyWrEn = 1'b1; stbyWrData = 1'b0; step(); stbyWrEn = 1'b0;
    chk("R7", "clear on lock edge still locks", status, 2'b10);
    porPulse();

    // R6 clear on the edge reaching 80 returns to running
    setIdle(1'b1); step(); step();
    enterStandby(8'hFE);
    nmiIn = 1'b1;
    settle(8'hFE, 8'h1C);
    tick = 1'b1;
    for (int i = 0; i < 127; i++) step();
    stbyWrEn = 1'b1; stbyWrData = 1'b0; step(); stbyWrEn = 1'b0;
    tick = 1'b0; step();
    chk("R6", "early clear runs", status, 2'b00);
    tick = 1'b1; step(); step(); tick = 1'b0;
    chk("R6", "early clear cnt frozen", cntVal, 8'h80);
    chk("R6", "early clear no lock", status, 2'b00);

    // R9 running: refused with flag set, accepted when clear
    stbyWrEn = 1'b1; stbyWrData = 1'b1; step(); stbyWrEn = 1'b0;
    manRstN = 1'b0; step();
    chk("R9", "refused with flag set", chipRstN, 1);
    stbyWrEn = 1'b1; stbyWrData = 1'b0; step(); stbyWrEn = 1'b0;
    step();
    chk("R9", "accepted with flag clear", chipRstN, 0);
    step();
    chk("R9", "held while low", chipRstN, 0);
    manRstN = 1'b1; step();
    chk("R9", "released", chipRstN, 1);

    // R10 manual reset cancels standby
    setIdle(1'b1); step();
    enterStandby(8'hF0);
    manRstN = 1'b0; step();
    chk("R10", "reset held in standby cancel", chipRstN, 0);
    chk("R10", "running after cancel", status, 2'b00);
    chk("R10", "clock kept on", chipClkEn, 1);
    step();
    chk("R10", "still held", chipRstN, 0);
    manRstN = 1'b1; step();
    chk("R10", "released", chipRstN, 1);
    sleepReq = 1'b1; step(); sleepReq = 1'b0;
    chk("R10", "flag cleared by cancel", status, 2'b00);

    // R10 during settling
    enterStandby(8'hF0);
    nmiIn = 1'b0; step(); nmiIn = 1'b1; step();
    chk("R3", "settling", status, 2'b11);
    manRstN = 1'b0; step();
    chk("R10", "settle cancelled", status, 2'b00);
    chk("R10", "reset held", chipRstN, 0);
    manRstN = 1'b1; step();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule